// File: doc/BRIEF.md
# Byte ALU with Condition Flag Generation

This is a purely combinational arithmetic and logic unit for a small 8-bit controller datapath. One operation code selects among binary add and subtract, with or without the incoming carry, and decimal correction of a packed-BCD sum. It also covers bitwise AND, OR, XOR and one's complement, four rotate forms, and increment and decrement. The unit returns the result byte and the new carry, half carry, zero and signed overflow flags. It also returns a write mask that tells the surrounding status register which of those four flags the operation is allowed to change.

Flags that an operation does not own come back unchanged (carry and half carry) or cleared (zero and overflow), so a status register can load each flag under its mask bit without further logic. A separate zero indication tells whether the result byte is zero for every operation, whatever the mask says. The instruction sequencer uses it for skip-if-zero style branch decisions. Every output settles within the same cycle as the inputs; the unit holds no state, has no handshake, and applies no back-pressure.

Top module: `alu8_flags`

## Requirements
- R1: Operation codes 0 (add) and 1 (add with carry) give result = A + B + cin, where cin is 0 for code 0 and the carry input for code 1. Carry out is bit 8 of that sum and half carry is the carry out of bit 3. The mask is 4'b1111; mask bit 0 is carry, bit 1 is half carry, bit 2 is zero and bit 3 is overflow.
- R2: Operation codes 2 (subtract) and 3 (subtract with borrow) give result = A - B - bin, where bin is 0 for code 2 and the inverse of the carry input for code 3. Carry out is 1 when the full subtraction needs no borrow. Half carry is 1 when the low-nibble subtraction needs no borrow. The mask is 4'b1111.
- R3: For codes 0 to 3, overflow equals carry into bit 7 XOR carry out of bit 7. This is the same as the signed result leaving the range -128..127.
- R4: Whenever mask bit 2 is set, the zero output is 1 exactly when the result byte is 00h.
- R5: Code 4 (decimal correction) first adds 06h when the low nibble of A exceeds 9 or the half-carry input is 1. It then adds 60h when the intermediate high nibble exceeds 9, the first add carried out of bit 7, or the carry input is 1. Carry out is the carry input OR that second adjust, and the mask is 4'b0101.
- R6: Codes 5, 6 and 7 give A AND B, A OR B and A XOR B. Code 8 gives the complement of A. All four have mask 4'b0100.
- R7: Code 9 rotates A left by one bit and code 10 rotates it right by one bit, both within the byte. The mask is 4'b0000, so carry passes through unchanged.
- R8: Code 11 shifts A left with the carry input entering bit 0 and bit 7 leaving as carry out. Code 12 shifts A right with the carry input entering bit 7 and bit 0 leaving as carry out. Both have mask 4'b0001.
- R9: Code 13 gives A + 1 and code 14 gives A - 1, both wrapping modulo 256, with mask 4'b0100.
- R10: For each flag whose mask bit is 0, carry and half carry outputs equal their inputs, and zero and overflow outputs are 0.
- R11: The zero indication output is 1 exactly when the result byte is 00h, for all sixteen codes.
- R12: Code 15 is reserved: the result equals A and the mask is 4'b0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code, values 0 to 15 as listed in the requirements |
| a_i | input | 8 | First operand; the only operand of single-operand codes |
| b_i | input | 8 | Second operand |
| c_i | input | 1 | Current carry flag (1 means no borrow after a subtraction) |
| ac_i | input | 1 | Current half-carry flag |
| res_o | output | 8 | Result byte |
| c_o | output | 1 | Carry flag to write back |
| ac_o | output | 1 | Half-carry flag to write back |
| z_o | output | 1 | Zero flag to write back |
| ov_o | output | 1 | Overflow flag to write back |
| wmask_o | output | 4 | Flag write mask: bit 0 carry, bit 1 half carry, bit 2 zero, bit 3 overflow |
| zero_o | output | 1 | Result-is-zero indication for skip decisions |

## Verification
The bench builds the unit with its default widths, an 8-bit data path split into 4-bit nibbles. At that size every single-operand code can be swept over all 256 operand values with all four combinations of incoming carry and half carry. That covers the decimal correction cases at 99h, 9Ah and FAh, and the rotate-through-carry boundaries. The four two-operand arithmetic codes are checked at the sign and nibble edges (00h, 01h, 0Fh, 7Fh, 80h, FFh) crossed with both carry values, followed by a random operand stream. Every vector goes through a behavioural reference written in integer arithmetic.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int OP_W   = 4;
  localparam int FLAG_N = 4;

  // Positions inside the flag write mask
  localparam int FC  = 0;
  localparam int FAC = 1;
  localparam int FZ  = 2;
  localparam int FOV = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBB = 4'd3,
    OP_DAJ = 4'd4,
    OP_AND = 4'd5,
    OP_OR  = 4'd6,
    OP_XOR = 4'd7,
    OP_CPL = 4'd8,
    OP_ROL = 4'd9,
    OP_ROR = 4'd10,
    OP_RLC = 4'd11,
    OP_RRC = 4'd12,
    OP_INC = 4'd13,
    OP_DEC = 4'd14,
    OP_NOP = 4'd15
  } alu_op_e;

endpackage

// File: rtl/alu_addsub.sv
// Shared adder: add or subtract (operand inversion) with carry taps at the
// nibble boundary and on both sides of the most significant bit.
module alu_addsub #(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              nib_c_o,
  output logic              msb_cin_o,
  output logic              cout_o
);

  localparam int MID_W = DATA_W - 1 - NIB_W;

  logic [DATA_W-1:0] b_eff;
  logic [NIB_W:0]    lo_sum;
  logic [MID_W:0]    mid_sum;
  logic [1:0]        top_sum;

  assign b_eff = sub_i ? ~b_i : b_i;

  assign lo_sum  = {1'b0, a_i[NIB_W-1:0]} + {1'b0, b_eff[NIB_W-1:0]}
                 + {{NIB_W{1'b0}}, cin_i};
  assign mid_sum = {1'b0, a_i[DATA_W-2:NIB_W]} + {1'b0, b_eff[DATA_W-2:NIB_W]}
                 + {{MID_W{1'b0}}, lo_sum[NIB_W]};
  assign top_sum = {1'b0, a_i[DATA_W-1]} + {1'b0, b_eff[DATA_W-1]}
                 + {1'b0, mid_sum[MID_W]};

  assign sum_o     = {top_sum[0], mid_sum[MID_W-1:0], lo_sum[NIB_W-1:0]};
  assign nib_c_o   = lo_sum[NIB_W];
  assign msb_cin_o = mid_sum[MID_W];
  assign cout_o    = top_sum[1];

endmodule

// File: rtl/alu_decadj.sv
// Decimal correction: one adjust stage per nibble, lowest first. The lowest
// stage is forced by the half-carry input, the highest by the carry input or
// by a carry rippling out of the lower adjusts.
module alu_decadj #(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic              c_i,
  input  logic              ac_i,
  output logic [DATA_W-1:0] res_o,
  output logic              up_o
);

  localparam int NIB_N = DATA_W / NIB_W;
  localparam logic [NIB_W-1:0] DIGIT_MAX = NIB_W'(9);
  localparam logic [DATA_W:0]  STEP      = (DATA_W+1)'(6);

  logic [DATA_W:0]  stage [NIB_N+1];
  logic [NIB_N-1:0] need;
  logic             unused_top_carry;

  assign stage[0] = {1'b0, a_i};

  for (genvar k = 0; k < NIB_N; k++) begin : g_nib
    logic             force_adj;
    logic [NIB_W-1:0] digit;

    assign digit = stage[k][k*NIB_W +: NIB_W];

    if (k == 0) begin : g_low
      assign force_adj = ac_i;
    end else if (k == NIB_N - 1) begin : g_high
      assign force_adj = c_i | stage[k][DATA_W];
    end else begin : g_mid
      assign force_adj = 1'b0;
    end

    assign need[k]    = force_adj | (digit > DIGIT_MAX);
    assign stage[k+1] = stage[k] + (need[k] ? (STEP << (k*NIB_W)) : '0);
  end

  assign res_o            = stage[NIB_N][DATA_W-1:0];
  assign up_o             = need[NIB_N-1];
  assign unused_top_carry = stage[NIB_N][DATA_W];

endmodule

// File: rtl/alu_bitops.sv
// Bitwise logic and the four rotate forms.
module alu_bitops
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              c_i,
  output logic [DATA_W-1:0] res_o,
  output logic              c_o
);

  always_comb begin
    res_o = a_i;
    c_o   = c_i;
    case (op_i)
      OP_AND: res_o = a_i & b_i;
      OP_OR:  res_o = a_i | b_i;
      OP_XOR: res_o = a_i ^ b_i;
      OP_CPL: res_o = ~a_i;
      OP_ROL: res_o = {a_i[DATA_W-2:0], a_i[DATA_W-1]};
      OP_ROR: res_o = {a_i[0], a_i[DATA_W-1:1]};
      OP_RLC: begin
        res_o = {a_i[DATA_W-2:0], c_i};
        c_o   = a_i[DATA_W-1];
      end
      OP_RRC: begin
        res_o = {c_i, a_i[DATA_W-1:1]};
        c_o   = a_i[0];
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              c_i,
  input  logic              ac_i,
  output logic [DATA_W-1:0] res_o,
  output logic              c_o,
  output logic              ac_o,
  output logic              z_o,
  output logic              ov_o,
  output logic [FLAG_N-1:0] wmask_o,
  output logic              zero_o
);

  localparam logic [FLAG_N-1:0] M_NONE  = '0;
  localparam logic [FLAG_N-1:0] M_ALL   = '1;
  localparam logic [FLAG_N-1:0] M_C     = FLAG_N'(1) << FC;
  localparam logic [FLAG_N-1:0] M_Z     = FLAG_N'(1) << FZ;
  localparam logic [FLAG_N-1:0] M_DECAD = M_C | M_Z;

  alu_op_e op;
  assign op = alu_op_e'(op_i);

  // Adder operand steering
  logic              as_sub, as_cin;
  logic [DATA_W-1:0] as_b, as_sum;
  logic              as_nib, as_c7, as_c8;

  always_comb begin
    as_sub = 1'b0;
    as_cin = 1'b0;
    as_b   = b_i;
    case (op)
      OP_ADC: as_cin = c_i;
      OP_SUB: begin as_sub = 1'b1; as_cin = 1'b1; end
      OP_SBB: begin as_sub = 1'b1; as_cin = c_i;  end
      OP_INC: begin as_b = '0; as_cin = 1'b1; end
      OP_DEC: begin as_sub = 1'b1; as_b = DATA_W'(1); as_cin = 1'b1; end
      default: ;
    endcase
  end

  alu_addsub #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_addsub (
    .a_i      (a_i),
    .b_i      (as_b),
    .sub_i    (as_sub),
    .cin_i    (as_cin),
    .sum_o    (as_sum),
    .nib_c_o  (as_nib),
    .msb_cin_o(as_c7),
    .cout_o   (as_c8)
  );

  logic [DATA_W-1:0] da_res;
  logic              da_up;

  alu_decadj #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_decadj (
    .a_i  (a_i),
    .c_i  (c_i),
    .ac_i (ac_i),
    .res_o(da_res),
    .up_o (da_up)
  );

  logic [DATA_W-1:0] bo_res;
  logic              bo_c;

  alu_bitops #(.DATA_W(DATA_W)) u_bitops (
    .op_i (op),
    .a_i  (a_i),
    .b_i  (b_i),
    .c_i  (c_i),
    .res_o(bo_res),
    .c_o  (bo_c)
  );

  // Result selection, new flag values and write mask
  logic [DATA_W-1:0] res;
  logic [FLAG_N-1:0] mask;
  logic              c_new;

  always_comb begin
    res   = a_i;
    mask  = M_NONE;
    c_new = c_i;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
        res   = as_sum;
        mask  = M_ALL;
        c_new = as_c8;
      end
      OP_INC, OP_DEC: begin
        res  = as_sum;
        mask = M_Z;
      end
      OP_DAJ: begin
        res   = da_res;
        mask  = M_DECAD;
        c_new = c_i | da_up;
      end
      OP_AND, OP_OR, OP_XOR, OP_CPL: begin
        res  = bo_res;
        mask = M_Z;
      end
      OP_ROL, OP_ROR: begin
        res  = bo_res;
        mask = M_NONE;
      end
      OP_RLC, OP_RRC: begin
        res   = bo_res;
        mask  = M_C;
        c_new = bo_c;
      end
      default: begin
        res  = a_i;
        mask = M_NONE;
      end
    endcase
  end

  logic res_zero;
  assign res_zero = (res == '0);

  assign res_o   = res;
  assign wmask_o = mask;
  assign zero_o  = res_zero;
  assign c_o     = mask[FC]  ? c_new           : c_i;
  assign ac_o    = mask[FAC] ? as_nib          : ac_i;
  assign z_o     = mask[FZ]  & res_zero;
  assign ov_o    = mask[FOV] & (as_c7 ^ as_c8);

endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic [OP_W-1:0]   op_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic              c_i,
  input logic              ac_i,
  input logic [DATA_W-1:0] res_o,
  input logic              c_o,
  input logic              ac_o,
  input logic              z_o,
  input logic              ov_o,
  input logic [FLAG_N-1:0] wmask_o
);

  localparam int MSB = DATA_W - 1;

  always_comb begin
    if (!$isunknown({op_i, a_i, b_i, c_i, ac_i})) begin
      assert_add_sum_R1: assert (op_i != OP_ADD ||
                                 {c_o, res_o} == ({1'b0, a_i} + {1'b0, b_i}))
        else $error("add sum or carry wrong");
      assert_sub_noborrow_R2: assert (op_i != OP_SUB ||
                                      (res_o == a_i - b_i && c_o == (a_i >= b_i)))
        else $error("subtract result or no-borrow carry wrong");
      assert_add_overflow_R3: assert (!(op_i == OP_ADD || op_i == OP_ADC) ||
          ov_o == (a_i[MSB] == b_i[MSB] && res_o[MSB] != a_i[MSB]))
        else $error("add overflow wrong");
      assert_sub_overflow_R3: assert (!(op_i == OP_SUB || op_i == OP_SBB) ||
          ov_o == (a_i[MSB] != b_i[MSB] && res_o[MSB] != a_i[MSB]))
        else $error("subtract overflow wrong");
      assert_zero_flag_R4: assert (!wmask_o[FZ] || z_o == (res_o == '0))
        else $error("zero flag disagrees with result");
      assert_logic_mask_R6: assert (!(op_i == OP_AND || op_i == OP_OR ||
                                      op_i == OP_XOR || op_i == OP_CPL) ||
                                    wmask_o == (FLAG_N'(1) << FZ))
        else $error("logic op mask wrong");
      assert_rotate_keep_R7: assert (!(op_i == OP_ROL || op_i == OP_ROR) ||
          (c_o == c_i && wmask_o == '0 && $countones(res_o) == $countones(a_i)))
        else $error("plain rotate changed carry or bit count");
      assert_rlc_carry_R8: assert (op_i != OP_RLC ||
                                   (c_o == a_i[MSB] && res_o[0] == c_i))
        else $error("rotate left through carry wrong");
      assert_rrc_carry_R8: assert (op_i != OP_RRC ||
                                   (c_o == a_i[0] && res_o[MSB] == c_i))
        else $error("rotate right through carry wrong");
      assert_inc_wrap_R9: assert (op_i != OP_INC || res_o == a_i + DATA_W'(1))
        else $error("increment wrong");
      assert_keep_c_R10: assert (wmask_o[FC] || c_o == c_i)
        else $error("unowned carry changed");
      assert_keep_ac_R10: assert (wmask_o[FAC] || ac_o == ac_i)
        else $error("unowned half carry changed");
      assert_clear_zo_R10: assert (wmask_o[FZ] || wmask_o[FOV] || (!z_o && !ov_o))
        else $error("unowned zero or overflow not cleared");
      assert_reserved_R12: assert (op_i != OP_NOP || (res_o == a_i && wmask_o == '0))
        else $error("reserved code not a pass-through");
    end
  end

endmodule

bind alu8_flags alu8_flags_chk #(.DATA_W(DATA_W)) u_chk (
  .op_i   (op_i),
  .a_i    (a_i),
  .b_i    (b_i),
  .c_i    (c_i),
  .ac_i   (ac_i),
  .res_o  (res_o),
  .c_o    (c_o),
  .ac_o   (ac_o),
  .z_o    (z_o),
  .ov_o   (ov_o),
  .wmask_o(wmask_o)
);

// File: tb/test_alu8_flags.sv
`timescale 1ns/1ps
module test_alu8_flags;

  logic       clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [3:0] op;
  logic [7:0] a, b;
  logic       c, ac;
  logic [7:0] res;
  logic       c_o, ac_o, z_o, ov_o, zero_o;
  logic [3:0] wmask;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  alu8_flags i_alu8_flags (
    .op_i   (op),
    .a_i    (a),
    .b_i    (b),
    .c_i    (c),
    .ac_i   (ac),
    .res_o  (res),
    .c_o    (c_o),
    .ac_o   (ac_o),
    .z_o    (z_o),
    .ov_o   (ov_o),
    .wmask_o(wmask),
    .zero_o (zero_o)
  );

  typedef struct {
    int res;
    int c;
    int ac;
    int z;
    int ov;
    int mask;
  } exp_t;

  // Behavioural reference in plain integer arithmetic
  function automatic exp_t model(int o, int va, int vb, int vc, int vac);
    exp_t e;
    int   nc, nac, nov, s, t, bin, up;
    nc = vc; nac = vac; nov = 0;
    e.res = va; e.mask = 0;
    case (o)
      0, 1: begin                                   // R1
        s     = va + vb + ((o == 1) ? vc : 0);
        e.res = s % 256;
        nc    = (s > 255) ? 1 : 0;
        nac   = (((va % 16) + (vb % 16) + ((o == 1) ? vc : 0)) > 15) ? 1 : 0;
        nov   = ((va >= 128) == (vb >= 128) && (e.res >= 128) != (va >= 128)) ? 1 : 0;
        e.mask = 15;
      end
      2, 3: begin                                   // R2
        bin   = (o == 2) ? 0 : 1 - vc;
        s     = va - vb - bin;
        e.res = (s + 512) % 256;
        nc    = (s >= 0) ? 1 : 0;
        nac   = (((va % 16) - (vb % 16) - bin) >= 0) ? 1 : 0;
        nov   = ((va >= 128) != (vb >= 128) && (e.res >= 128) != (va >= 128)) ? 1 : 0;
        e.mask = 15;
      end
      4: begin                                      // R5
        t     = va + (((va % 16) > 9 || vac == 1) ? 6 : 0);
        up    = (t > 255 || ((t / 16) % 16) > 9 || vc == 1) ? 1 : 0;
        e.res = (t + ((up == 1) ? 96 : 0)) % 256;
        nc    = (vc == 1 || up == 1) ? 1 : 0;
        e.mask = 5;
      end
      5:  begin e.res = va & vb;       e.mask = 4; end
      6:  begin e.res = va | vb;       e.mask = 4; end
      7:  begin e.res = va ^ vb;       e.mask = 4; end
      8:  begin e.res = 255 - va;      e.mask = 4; end
      9:  begin e.res = (va * 2) % 256 + va / 128;           e.mask = 0; end
      10: begin e.res = va / 2 + (va % 2) * 128;             e.mask = 0; end
      11: begin e.res = (va * 2) % 256 + vc; nc = va / 128;  e.mask = 1; end
      12: begin e.res = va / 2 + vc * 128;   nc = va % 2;    e.mask = 1; end
      13: begin e.res = (va + 1) % 256;   e.mask = 4; end
      14: begin e.res = (va + 255) % 256; e.mask = 4; end
      default: begin e.res = va; e.mask = 0; end     // R12
    endcase
    e.c  = ((e.mask & 1) != 0) ? nc : vc;
    e.ac = ((e.mask & 2) != 0) ? nac : vac;
    e.z  = ((e.mask & 4) != 0 && e.res == 0) ? 1 : 0;
    e.ov = ((e.mask & 8) != 0) ? nov : 0;
    return e;
  endfunction

  function automatic string req_of(int o);
    case (o)
      0, 1:           return "R1";
      2, 3:           return "R2";
      4:              return "R5";
      5, 6, 7, 8:     return "R6";
      9, 10:          return "R7";
      11, 12:         return "R8";
      13, 14:         return "R9";
      default:        return "R12";
    endcase
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s op=%0d a=%02h b=%02h c=%0d ac=%0d actual=%0h expected=%0h",
               req, what, op, a, b, c, ac, act, exp);
    end
  endtask

  task automatic run_vec(int o, int va, int vb, int vc, int vac);
    exp_t e;
    @(posedge clk);
    op = o[3:0]; a = va[7:0]; b = vb[7:0]; c = vc[0]; ac = vac[0];
    @(negedge clk);
    e = model(o, va, vb, vc, vac);
    chk(req_of(o), "result", int'(res), e.res);
    chk(req_of(o), "mask", int'(wmask), e.mask);
    chk(((e.mask & 1) != 0) ? req_of(o) : "R10", "carry", int'(c_o), e.c);
    chk(((e.mask & 2) != 0) ? req_of(o) : "R10", "halfcarry", int'(ac_o), e.ac);
    chk(((e.mask & 4) != 0) ? "R4" : "R10", "zero", int'(z_o), e.z);
    chk(((e.mask & 8) != 0) ? "R3" : "R10", "overflow", int'(ov_o), e.ov);
    chk("R11", "zero_test", int'(zero_o), (e.res == 0) ? 1 : 0);
  endtask

  int edge_val [6] = '{0, 1, 15, 127, 128, 255};

  initial begin
    op = 4'd0; a = 8'd0; b = 8'd0; c = 1'b0; ac = 1'b0;
    for (int o = 0; o < 16; o++) begin
      if (o < 4) begin
        // R1 R2 R3: sign and nibble edges, then random operands
        for (int i = 0; i < 6; i++)
          for (int j = 0; j < 6; j++)
            for (int k = 0; k < 2; k++)
              run_vec(o, edge_val[i], edge_val[j], k, 0);
        for (int n = 0; n < 2000; n++)
          run_vec(o, int'($urandom % 256), int'($urandom % 256),
                  int'($urandom % 2), int'($urandom % 2));
      end else begin
        // R5..R12: exhaustive over A and both incoming flags
        for (int va = 0; va < 256; va++)
          for (int vc = 0; vc < 2; vc++)
            for (int vac = 0; vac < 2; vac++)
              run_vec(o, va, int'($urandom % 256), vc, vac);
      end
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule